// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is one channel of an interval timer. It holds a 16-bit down-counter that advances on a counter clock enable (`tick`) and is controlled by a `gate` input. A mode write selects one of six counting behaviours. A load strobe then supplies the initial count N, where a loaded value of 0 stands for 65536. The block shows the current count and an output waveform `out` whose shape depends on the mode. It also gives a one-cycle `expire` pulse at each terminal count, which interrupt logic can use.

In the requirements below, d is the number of counted ticks since the last load or restart. A tick is counted when `tick` is high on a clock edge and counting is enabled for the mode. Mode codes are 0 (interrupt on terminal count), 1 (gate-triggered one-shot), 2 (rate generator), 3 (square wave), 4 (software strobe) and 5 (gate-triggered strobe). All counting is binary.

Top module: `timer_channel`

## Requirements
- R1: A load strobe with value v arms the channel with N = v, or N = 65536 when v is 0, and sets d to 0. On the edge that takes the load, the count output shows N mod 65536.
- R2: After reset, and after any mode write that comes without a load, the channel is idle: `out` and `expire` stay low and ticks are not counted. After reset `count` is 0.
- R3: In modes 0, 1, 4 and 5 the count shows (N − d) mod 65536. Past zero it wraps to 0xFFFF and keeps going down.
- R4: In mode 0, `out` is high exactly when d ≥ N. In mode 1, `out` is high exactly when d < N.
- R5: In modes 4 and 5, `out` is high only while d equals N.
- R6: In mode 2 the count shows N − (d mod N), taken mod 65536. `out` is high while d is a nonzero multiple of N.
- R7: In mode 3 the count shows N − (2d mod N), taken mod 65536. `out` is high while (d mod N) < (N+1)/2, using integer division.
- R8: In modes 0, 2, 3 and 4 a tick is counted only while `gate` is high. In modes 1 and 5 ticks are counted whatever `gate` is.
- R9: In modes 1, 2, 3 and 5, a rising edge of `gate` sets d to 0, and no tick is counted on that edge. In modes 0 and 4 a rising gate edge does not restart the count.
- R10: `expire` is high for one cycle after the edge on which d reaches N (modes 0, 1, 4, 5; at most once per load or restart). In modes 2 and 3 it is high after each edge on which d becomes a nonzero multiple of N.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: A mode write and a load in the same cycle arm the channel in the new mode with the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load strobe for the initial count |
| load_val | input | 16 | Initial count (0 means 65536) |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code 0..7 |
| gate | input | 1 | Gate: enable, hold or retrigger |
| tick | input | 1 | Counter clock enable |
| count | output | 16 | Current count value |
| out | output | 1 | Mode-dependent output waveform |
| expire | output | 1 | One-cycle pulse at terminal count |

## Verification
Each of `count`, `out` and `expire` takes its new value on the same clock edge that samples the load, mode write, tick or gate edge that caused it. There is no further pipeline stage. The bench drives every input on the falling edge and compares all three outputs on the following falling edge, against a model that tracks d and evaluates the mode formulas directly. It sweeps every mode against several counts and three tick and gate patterns. Two extra runs cover the aliased mode codes, and one full 65536-tick run covers a loaded zero.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } tmode_e;

    // codes 6 and 7 alias the periodic modes
    function automatic tmode_e fold_mode(input logic [2:0] m);
        return (m > 3'd5) ? tmode_e'(m - 3'd4) : tmode_e'(m);
    endfunction

    function automatic logic is_periodic(input tmode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic gate_retrig(input tmode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
    endfunction

    function automatic logic gate_free(input tmode_e m);
        return (m == M_ONESHOT) || (m == M_HW_STROBE);
    endfunction

endpackage

// File: rtl/tc_modstep.sv
// (cur + STEP) mod lim, assuming cur <= lim
module tc_modstep #(
    parameter int CW   = 17,
    parameter int STEP = 1
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] nxt
);
    localparam int SW = CW + 1;

    logic [SW-1:0] s1;
    logic [SW-1:0] s2;

    always_comb begin
        s1 = {1'b0, cur} + SW'(STEP);
        if (s1 >= {1'b0, lim}) s1 = s1 - {1'b0, lim};
    end

    if (STEP > 1) begin : g_two_stage
        always_comb begin
            s2 = s1;
            if (s1 >= {1'b0, lim}) s2 = s1 - {1'b0, lim};
        end
    end else begin : g_one_stage
        assign s2 = s1;
    end

    assign nxt = s2[CW-1:0];

    // R7: the reduced sum always fits the counter width
    always_comb begin
        a_r7_step_fits: assert (s2[CW] == 1'b0);
    end

endmodule

// File: rtl/tc_core.sv
module tc_core
    import timer_chan_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          mode_wr,
    input  logic [2:0]    mode_in,
    input  logic          gate,
    input  logic          tick,
    output logic          armed_o,
    output tmode_e        mode_o,
    output logic [CW-1:0] init_o,
    output logic [CW-1:0] ph_o,
    output logic [CW-1:0] dbl_o,
    output logic [W-1:0]  cnt_o,
    output logic          done_o,
    output logic          tc_o,
    output logic          expire_o
);
    typedef struct packed {
        logic          armed;
        tmode_e        mode;
        logic [CW-1:0] init;
        logic [CW-1:0] ph;
        logic [CW-1:0] dbl;
        logic [W-1:0]  cnt;
        logic          done;
        logic          tc;
        logic          expire;
        logic          gate_q;
    } st_t;

    st_t st_d, st_q;
    logic rise, restart, run;
    logic [CW-1:0] ph_nx, dbl_nx;

    tc_modstep #(.CW(CW), .STEP(1)) u_phase (.cur(st_q.ph),  .lim(st_q.init), .nxt(ph_nx));
    tc_modstep #(.CW(CW), .STEP(2)) u_dbl   (.cur(st_q.dbl), .lim(st_q.init), .nxt(dbl_nx));

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        st_d.gate_q = gate;
        rise    = gate & ~st_q.gate_q;
        restart = st_q.armed & rise & gate_retrig(st_q.mode);
        run     = st_q.armed & tick & (gate | gate_free(st_q.mode));
        if (mode_wr || load) begin
            if (mode_wr) begin
                st_d.mode  = fold_mode(mode_in);
                st_d.armed = 1'b0;
                st_d.done  = 1'b0;
                st_d.tc    = 1'b0;
            end
            if (load) begin
                st_d.init  = (load_val == '0) ? {1'b1, {W{1'b0}}} : {1'b0, load_val};
                st_d.cnt   = load_val;
                st_d.ph    = '0;
                st_d.dbl   = '0;
                st_d.done  = 1'b0;
                st_d.tc    = 1'b0;
                st_d.armed = 1'b1;
            end
        end else if (restart) begin
            st_d.cnt  = W'(st_q.init);
            st_d.ph   = '0;
            st_d.dbl  = '0;
            st_d.done = 1'b0;
            st_d.tc   = 1'b0;
        end else if (run) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.tc  = 1'b0;
            if (is_periodic(st_q.mode)) begin
                st_d.ph  = ph_nx;
                st_d.dbl = dbl_nx;
                if (ph_nx == '0) begin
                    st_d.tc     = 1'b1;
                    st_d.expire = 1'b1;
                end
            end else if (!st_q.done) begin
                st_d.ph = st_q.ph + 1'b1;
                if (st_q.ph + 1'b1 == st_q.init) begin
                    st_d.done   = 1'b1;
                    st_d.tc     = 1'b1;
                    st_d.expire = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o  = st_q.armed;
    assign mode_o   = st_q.mode;
    assign init_o   = st_q.init;
    assign ph_o     = st_q.ph;
    assign dbl_o    = st_q.dbl;
    assign cnt_o    = st_q.cnt;
    assign done_o   = st_q.done;
    assign tc_o     = st_q.tc;
    assign expire_o = st_q.expire;

    // R1: a load arms the channel with a cleared phase and the raw value shown
    a_r1_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.armed && st_q.ph == '0 && st_q.cnt == $past(load_val)));

    // R2: an idle channel never pulses
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> !st_q.expire);

    // R3: one-shot modes wrap from zero to all ones
    a_r3_wrap_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !load && !mode_wr && !is_periodic(st_q.mode) && st_q.cnt == '0)
        |=> st_q.cnt == '1);

    // R6: periodic modes reload at the end of each period and pulse expire
    a_r6_period_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !load && !mode_wr && is_periodic(st_q.mode) && st_q.ph + 1'b1 == st_q.init)
        |=> (st_q.ph == '0 && st_q.expire));

    // R7: square-wave phases stay below the period
    a_r7_square_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && st_q.mode == M_SQUARE) |-> (st_q.dbl < st_q.init && st_q.ph < st_q.init));

    // R8: without a tick, restart or write the counter holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !tick && !load && !mode_wr && !restart) |=> ($stable(st_q.cnt) && $stable(st_q.ph)));

    // R10: one-shot expire lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.expire && !is_periodic(st_q.mode)) |=> !st_q.expire);

endmodule

// File: rtl/tc_view.sv
module tc_view
    import timer_chan_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = W + 1
) (
    input  logic          armed,
    input  tmode_e        mode,
    input  logic [CW-1:0] init,
    input  logic [CW-1:0] ph,
    input  logic [CW-1:0] dbl,
    input  logic [W-1:0]  cnt,
    input  logic          done,
    input  logic          tc,
    output logic [W-1:0]  count,
    output logic          out
);
    logic [CW:0] half;
    logic        wave;

    always_comb begin
        half  = ({1'b0, init} + 1'b1) >> 1;
        count = cnt;
        wave  = 1'b0;
        unique case (mode)
            M_TC_INT:  wave = done;
            M_ONESHOT: wave = ~done;
            M_RATE: begin
                wave  = tc;
                count = W'(init - ph);
            end
            M_SQUARE: begin
                wave  = ({1'b0, ph} < half);
                count = W'(init - dbl);
            end
            default:   wave = tc;
        endcase
        out = armed & wave;
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         mode_wr,
    input  logic [2:0]   mode_in,
    input  logic         gate,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         out,
    output logic         expire
);
    localparam int CW = W + 1;

    logic          armed, done, tc;
    tmode_e        mode;
    logic [CW-1:0] init, ph, dbl;
    logic [W-1:0]  cnt;

    tc_core #(.W(W), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .mode_wr(mode_wr), .mode_in(mode_in), .gate(gate), .tick(tick),
        .armed_o(armed), .mode_o(mode), .init_o(init), .ph_o(ph), .dbl_o(dbl),
        .cnt_o(cnt), .done_o(done), .tc_o(tc), .expire_o(expire)
    );

    tc_view #(.W(W), .CW(CW)) u_view (
        .armed(armed), .mode(mode), .init(init), .ph(ph), .dbl(dbl),
        .cnt(cnt), .done(done), .tc(tc), .count(count), .out(out)
    );

endmodule

// File: tb/sim_timer_channel.sv
module sim_timer_channel;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        load = 1'b0, mode_wr = 1'b0, gate = 1'b0, tick = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_in = '0;
    logic [15:0] count;
    logic        out, expire;

    always #10 clk = ~clk;

    timer_channel #(.W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .mode_wr(mode_wr), .mode_in(mode_in), .gate(gate), .tick(tick),
        .count(count), .out(out), .expire(expire)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    int m_mode = 0, m_n = 1, m_d = 0;
    bit m_armed = 0, m_gprev = 0, m_exp = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (mode %0d N %0d d %0d)", tag, act, exp, m_mode, m_n, m_d);
        end
    endtask

    function automatic int fold(input int m);
        return (m > 5) ? m - 4 : m;
    endfunction

    function automatic int exp_count();
        case (m_mode)
            2:       return (m_n - (m_d % m_n)) & 16'hFFFF;
            3:       return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
            default: return (m_n - m_d) & 16'hFFFF;
        endcase
    endfunction

    function automatic int exp_out();
        case (m_mode)
            0:       return int'(m_d >= m_n);
            1:       return int'(m_d < m_n);
            2:       return int'((m_d % m_n) == 0 && m_d != 0);
            3:       return int'((m_d % m_n) < (m_n + 1) / 2);
            default: return int'(m_d == m_n);
        endcase
    endfunction

    task automatic compare(input string r);
        if (m_armed) begin
            check({r, " count"}, int'(count), exp_count());
            check({r, " out"}, int'(out), exp_out());
        end else begin
            check({r, " R2 idle out"}, int'(out), 0);
        end
        check({r, " R10 expire"}, int'(expire), int'(m_exp));
    endtask

    task automatic step(input bit tk, input bit gt, input string r);
        tick = tk;
        gate = gt;
        @(posedge clk);
        m_exp = 0;
        if (m_armed) begin
            if (gt && !m_gprev && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
                m_d = 0;
            end else if (tk && (gt || m_mode == 1 || m_mode == 5)) begin
                m_d++;
                if (m_mode == 2 || m_mode == 3) m_exp = ((m_d % m_n) == 0);
                else                            m_exp = (m_d == m_n);
            end
        end
        m_gprev = gt;
        @(negedge clk);
        compare(r);
    endtask

    task automatic program_ch(input int mcode, input int val, input bit together, input string r);
        if (!together) begin
            mode_wr = 1'b1; mode_in = 3'(mcode); gate = 1'b1; tick = 1'b1;
            @(posedge clk);
            m_mode = fold(mcode); m_armed = 0; m_exp = 0; m_gprev = 1;
            @(negedge clk);
            mode_wr = 1'b0;
            compare("R2");
            step(1, 1, "R2");
            step(1, 1, "R2");
        end
        load = 1'b1; load_val = 16'(val); mode_wr = together; mode_in = 3'(mcode);
        gate = 1'b1; tick = 1'b1;
        @(posedge clk);
        if (together) m_mode = fold(mcode);
        m_armed = 1; m_d = 0; m_n = (val == 0) ? 65536 : val; m_exp = 0; m_gprev = 1;
        @(negedge clk);
        load = 1'b0; mode_wr = 1'b0;
        compare(r);
    endtask

    function automatic bit pat_tick(input int p, input int i);
        case (p)
            1:       return (i % 2) == 0;
            2:       return (i % 3) != 2;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit pat_gate(input int p, input int i);
        if (p == 2) return !((i % 11) == 3 || (i % 11) == 4);
        return 1'b1;
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0, 1:    return "R3 R4";
            2:       return "R6";
            3:       return "R7";
            default: return "R3 R5";
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ns[5] = '{1, 2, 3, 4, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset out", int'(out), 0);
        check("R2 reset expire", int'(expire), 0);
        check("R2 reset count", int'(count), 0);
        for (int i = 0; i < 4; i++) step(1, 1, "R2 before load");

        for (int m = 0; m < 6; m++) begin
            foreach (ns[k]) begin
                for (int p = 0; p < 3; p++) begin
                    program_ch(m, ns[k], p == 1, (p == 1) ? "R12 R1" : "R1");
                    for (int i = 0; i < 3 * ns[k] + 8; i++)
                        step(pat_tick(p, i), pat_gate(p, i),
                             (p == 2) ? {mode_tag(m), " R8 R9"} : mode_tag(m));
                end
            end
        end

        // aliased mode codes
        program_ch(6, 5, 0, "R11");
        for (int i = 0; i < 20; i++) step(1, 1, "R11 R6");
        program_ch(7, 6, 1, "R11");
        for (int i = 0; i < 20; i++) step(pat_tick(2, i), pat_gate(2, i), "R11 R7");

        // loaded zero means 65536 ticks, then wrap continues
        program_ch(0, 0, 1, "R1");
        for (int i = 0; i < 65540; i++) step(1, 1, "R1 R3 R4");

        finish_run();
    end
endmodule